// File: doc/BRIEF.md
# Character Pattern Fetch and Override

This block turns the digit currently selected by the display scan into the drive levels for one column of a 5 by 7 dot character. From a 16-entry character-code store it reads an 8-bit code for that digit. Codes 0 to 7 take their dot pattern from a small writable pattern store. Every other code is sent out on a lookup port, and the fixed character table outside the block returns the pattern. The digit's two symbol bits come from their own 16-entry store and reach the auxiliary outputs without any pattern lookup.

All three stores are loaded through simple write ports by the command logic. The scan timer supplies the digit index, the blank window and the configured digit count. The registered result then passes through a priority override. Blanking and digits outside the configured count force every output low. The lamp flags then select all-lit, all-dark or normal display.

Top module: `glyph_fetch`

## Requirements
- R1: While `rst` is high and on the first edge after it, `seg_o` and `sym_o` are all zero. Reset sets the all-off flag and clears the all-on flag, so the outputs stay low until a flag write clears all-off.
- R2: A digit whose code is below 8 shows the pattern store entry addressed by code bits [2:0].
- R3: A digit whose code is 8 or higher shows `rom_pattern_i`. `rom_code_o` carries the code of the digit being read, in the same cycle.
- R4: Bit n of a 35-bit pattern drives `seg_o[n]` with no reordering. Only one output bit is high for a one-hot pattern.
- R5: The two symbol bits stored for a digit appear unchanged on `sym_o[1:0]`.
- R6: The outputs are registered. The value for the `digit_idx` presented before a rising edge appears after that edge, a latency of one clock.
- R7: With all-off set and all-on clear, both `seg_o` and `sym_o` are all zero.
- R8: With all-on set, every bit of `seg_o` and `sym_o` is one, whatever the value of all-off.
- R9: When `blank_i` is high, the next output is all zero. This holds even in the all-on state.
- R10: The digit-count code k selects the active digits. k = 0 means 16 digits, and k = 1 to 7 means 8 + k digits. A `digit_idx` at or above the count gives all-zero outputs.
- R11: A store write and a read of the same address in the same cycle return the old contents. The new contents appear from the next read onward.
- R12: The lamp flags load from `lamp_on_d` and `lamp_off_d` only in a cycle where `lamp_wr` is high. In any other cycle those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digit_idx | input | 4 | Digit being scanned (read address) |
| blank_i | input | 1 | Blank part of the digit slot |
| digit_cnt_code | input | 3 | Active digit count code (0 means 16, k means 8+k) |
| lamp_wr | input | 1 | Load strobe for the lamp flags |
| lamp_on_d | input | 1 | New all-on flag value |
| lamp_off_d | input | 1 | New all-off flag value |
| code_we | input | 1 | Character-code store write enable |
| code_waddr | input | 4 | Character-code store write address |
| code_wdata | input | 8 | Character code to store |
| pat_we | input | 1 | Pattern store write enable |
| pat_waddr | input | 3 | Pattern store write address |
| pat_wdata | input | 35 | Dot pattern to store |
| sym_we | input | 1 | Symbol store write enable |
| sym_waddr | input | 4 | Symbol store write address |
| sym_wdata | input | 2 | Symbol bits to store |
| rom_code_o | output | 8 | Code sent to the external fixed character table |
| rom_pattern_i | input | 35 | Pattern returned by the external table |
| seg_o | output | 35 | Segment drive levels |
| sym_o | output | 2 | Auxiliary symbol drive levels |

## Verification
The random run mixes codes below and above 8 with random pattern and symbol contents. This separates the store path from the external-table path and catches any mix-up of the pattern store index. Blanking, short digit counts and every combination of the lamp flags are interleaved at random, so the override priority is exercised against live data and not against all-zero contents. Directed cases cover the following: one-hot patterns at both ends and the middle of the segment field, which expose bit reordering; a write and a read of the same address in one cycle; a flag value presented without its strobe; and the first and last active digit for the 9-digit and 16-digit counts.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
    localparam int SEG_W       = 35;
    localparam int SYM_W       = 2;
    localparam int CODE_W      = 8;
    localparam int DIGITS      = 16;
    localparam int PAT_N       = 8;
    localparam int BASE_DIGITS = 8;
    localparam int CNT_W       = 3;
    localparam int DIG_AW      = $clog2(DIGITS);
    localparam int PAT_AW      = $clog2(PAT_N);
    localparam int LIMIT_W     = DIG_AW + 1;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [SYM_W-1:0]  sym_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        seg_t seg;
        sym_t sym;
    } glyph_t;

    typedef enum logic [1:0] {
        LAMP_NORMAL = 2'd0,
        LAMP_DARK   = 2'd1,
        LAMP_LIT    = 2'd2
    } lamp_e;

    // all-on wins over all-off
    function automatic lamp_e lamp_mode(input logic on_f, input logic off_f);
        if (on_f)  return LAMP_LIT;
        if (off_f) return LAMP_DARK;
        return LAMP_NORMAL;
    endfunction

    // code 0 selects the full digit count, otherwise base + code
    function automatic logic [LIMIT_W-1:0] digit_limit(input logic [CNT_W-1:0] k);
        if (k == '0) return LIMIT_W'(DIGITS);
        return LIMIT_W'(BASE_DIGITS) + LIMIT_W'(k);
    endfunction

    function automatic logic is_user_code(input code_t c);
        return c < CODE_W'(PAT_N);
    endfunction
endpackage

// File: rtl/glyph_ram.sv
module glyph_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // read sees contents before any write on this edge
    assign rdata = mem[raddr];
endmodule

// File: rtl/glyph_gate.sv
module glyph_gate
    import glyph_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  glyph_t raw_i,
    input  logic   blank_i,
    input  logic   active_i,
    input  lamp_e  lamp_i,
    output seg_t   seg_o,
    output sym_t   sym_o
);
    glyph_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (blank_i || !active_i) begin
            out_q <= '0;
        end else begin
            unique case (lamp_i)
                LAMP_LIT:  out_q <= '1;
                LAMP_DARK: out_q <= '0;
                default:   out_q <= raw_i;
            endcase
        end
    end

    assign seg_o = out_q.seg;
    assign sym_o = out_q.sym;

    assert_blank_low_R9: assert property (@(posedge clk) disable iff (rst)
        blank_i |=> (seg_o == '0 && sym_o == '0));

    assert_all_on_R8: assert property (@(posedge clk) disable iff (rst)
        (!blank_i && active_i && lamp_i == LAMP_LIT) |=> (&seg_o && &sym_o));

    assert_all_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!blank_i && active_i && lamp_i == LAMP_DARK) |=> (seg_o == '0 && sym_o == '0));
endmodule

// File: rtl/glyph_fetch.sv
module glyph_fetch
    import glyph_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DIG_AW-1:0] digit_idx,
    input  logic              blank_i,
    input  logic [CNT_W-1:0]  digit_cnt_code,
    input  logic              lamp_wr,
    input  logic              lamp_on_d,
    input  logic              lamp_off_d,
    input  logic              code_we,
    input  logic [DIG_AW-1:0] code_waddr,
    input  logic [CODE_W-1:0] code_wdata,
    input  logic              pat_we,
    input  logic [PAT_AW-1:0] pat_waddr,
    input  logic [SEG_W-1:0]  pat_wdata,
    input  logic              sym_we,
    input  logic [DIG_AW-1:0] sym_waddr,
    input  logic [SYM_W-1:0]  sym_wdata,
    output logic [CODE_W-1:0] rom_code_o,
    input  logic [SEG_W-1:0]  rom_pattern_i,
    output logic [SEG_W-1:0]  seg_o,
    output logic [SYM_W-1:0]  sym_o
);
    logic   lamp_on_q, lamp_off_q;
    code_t  cur_code;
    seg_t   user_pat;
    sym_t   cur_sym;
    glyph_t raw;
    logic   active;

    always_ff @(posedge clk) begin
        if (rst) begin
            lamp_on_q  <= 1'b0;
            lamp_off_q <= 1'b1;
        end else if (lamp_wr) begin
            lamp_on_q  <= lamp_on_d;
            lamp_off_q <= lamp_off_d;
        end
    end

    glyph_ram #(.DEPTH(DIGITS), .WIDTH(CODE_W)) u_code (
        .clk(clk), .we(code_we), .waddr(code_waddr), .wdata(code_wdata),
        .raddr(digit_idx), .rdata(cur_code)
    );

    glyph_ram #(.DEPTH(PAT_N), .WIDTH(SEG_W)) u_pat (
        .clk(clk), .we(pat_we), .waddr(pat_waddr), .wdata(pat_wdata),
        .raddr(cur_code[PAT_AW-1:0]), .rdata(user_pat)
    );

    glyph_ram #(.DEPTH(DIGITS), .WIDTH(SYM_W)) u_sym (
        .clk(clk), .we(sym_we), .waddr(sym_waddr), .wdata(sym_wdata),
        .raddr(digit_idx), .rdata(cur_sym)
    );

    assign rom_code_o = cur_code;
    assign raw.seg    = is_user_code(cur_code) ? user_pat : rom_pattern_i;
    assign raw.sym    = cur_sym;
    assign active     = {1'b0, digit_idx} < digit_limit(digit_cnt_code);

    glyph_gate u_gate (
        .clk(clk), .rst(rst), .raw_i(raw), .blank_i(blank_i),
        .active_i(active), .lamp_i(lamp_mode(lamp_on_q, lamp_off_q)),
        .seg_o(seg_o), .sym_o(sym_o)
    );

    // nine-digit setting: last scan slot must stay dark
    assert_nine_digit_dark_R10: assert property (@(posedge clk) disable iff (rst)
        (digit_cnt_code == 3'd1 && digit_idx == 4'd15) |=> (seg_o == '0 && sym_o == '0));
endmodule

// File: tb/sim_glyph_fetch.sv
module sim_glyph_fetch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  digit_idx = '0;
    logic        blank_i = 1'b0;
    logic [2:0]  digit_cnt_code = '0;
    logic        lamp_wr = 1'b0, lamp_on_d = 1'b0, lamp_off_d = 1'b0;
    logic        code_we = 1'b0;
    logic [3:0]  code_waddr = '0;
    logic [7:0]  code_wdata = '0;
    logic        pat_we = 1'b0;
    logic [2:0]  pat_waddr = '0;
    logic [34:0] pat_wdata = '0;
    logic        sym_we = 1'b0;
    logic [3:0]  sym_waddr = '0;
    logic [1:0]  sym_wdata = '0;
    logic [7:0]  rom_code_o;
    logic [34:0] rom_pattern_i;
    logic [34:0] seg_o;
    logic [1:0]  sym_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  code_m [16];
    logic [34:0] pat_m  [8];
    logic [1:0]  sym_m  [16];
    logic        on_m, off_m;

    always #5 clk = ~clk;

    function automatic logic [34:0] rom_fn(input logic [7:0] c);
        return {c[2:0], c, c ^ 8'h5A, ~c, c + 8'd3};
    endfunction

    assign rom_pattern_i = rom_fn(rom_code_o);

    glyph_fetch u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // inputs are set while clk is low; result is compared after the next rising edge
    task automatic step(input string ctag);
        logic [7:0]  c;
        logic [34:0] es;
        logic [1:0]  ey;
        logic [4:0]  lim;
        string       tag;
        c   = code_m[digit_idx];
        lim = (digit_cnt_code == 0) ? 5'd16 : 5'd8 + 5'(digit_cnt_code);
        if (blank_i)                  begin es = '0; ey = '0; tag = "R9"; end
        else if ({1'b0, digit_idx} >= lim) begin es = '0; ey = '0; tag = "R10"; end
        else if (on_m)                begin es = '1; ey = '1; tag = "R8"; end
        else if (off_m)               begin es = '0; ey = '0; tag = "R7"; end
        else begin
            es  = (c < 8) ? pat_m[c[2:0]] : rom_fn(c);
            ey  = sym_m[digit_idx];
            tag = (c < 8) ? "R2/R5" : "R3/R5";
        end
        #1;
        if (c >= 8) chk({"R3 rom code ", ctag}, 64'(rom_code_o), 64'(c));
        if (code_we) code_m[code_waddr] = code_wdata;
        if (pat_we)  pat_m[pat_waddr]   = pat_wdata;
        if (sym_we)  sym_m[sym_waddr]   = sym_wdata;
        if (lamp_wr) begin on_m = lamp_on_d; off_m = lamp_off_d; end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " seg R6 ", ctag}, 64'(seg_o), 64'(es));
        chk({tag, " sym R6 ", ctag}, 64'(sym_o), 64'(ey));
        code_we = 0; pat_we = 0; sym_we = 0; lamp_wr = 0;
    endtask

    task automatic set_flags(input logic on_v, input logic off_v);
        lamp_wr = 1; lamp_on_d = on_v; lamp_off_d = off_v;
        step("flag write");
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        on_m = 0; off_m = 1;
        repeat (3) @(negedge clk);
        chk("R1 reset seg", 64'(seg_o), 64'd0);
        chk("R1 reset sym", 64'(sym_o), 64'd0);
        rst = 0;
        @(negedge clk);
        chk("R1 after reset seg", 64'(seg_o), 64'd0);
        // load every store while all-off from reset keeps outputs dark
        for (int i = 0; i < 16; i++) begin
            digit_idx = 4'(i);
            code_we = 1; code_waddr = 4'(i); code_wdata = (i < 8) ? 8'(i) : 8'(8'h20 + i * 7);
            sym_we = 1; sym_waddr = 4'(i); sym_wdata = 2'(i);
            if (i < 8) begin pat_we = 1; pat_waddr = 3'(i); pat_wdata = 35'(64'h1_2345_6789 * (i + 1)); end
            step("R1 dark after reset");
        end
        set_flags(0, 0);
        // R12: flag values without strobe do nothing
        lamp_on_d = 1; lamp_off_d = 1; digit_idx = 4'd3;
        step("R12 no strobe");
        step("R12 no strobe hold");
        // R4: one-hot patterns
        foreach (pat_m[k]) begin end
        for (int b = 0; b < 35; b += 17) begin
            pat_we = 1; pat_waddr = 3'd2; pat_wdata = 35'b1 << b; digit_idx = 4'd0;
            step("R4 write");
            digit_idx = 4'd2;
            step("R4 one-hot");
        end
        // R6: new digit every cycle
        for (int i = 0; i < 16; i++) begin digit_idx = 4'(i); step("R6 sweep"); end
        // R11: same-cycle write and read
        digit_idx = 4'd5; code_we = 1; code_waddr = 4'd5; code_wdata = 8'hC3;
        step("R11 old data");
        step("R11 new data");
        digit_idx = 4'd5; sym_we = 1; sym_waddr = 4'd5; sym_wdata = ~sym_m[5];
        step("R11 sym old");
        step("R11 sym new");
        // R10 boundaries
        digit_cnt_code = 3'd1; digit_idx = 4'd8;  step("R10 ninth digit active");
        digit_idx = 4'd9;  step("R10 tenth digit dark");
        digit_cnt_code = 3'd0; digit_idx = 4'd15; step("R10 sixteenth active");
        // lamp modes including priority and blanking
        set_flags(1, 1); digit_idx = 4'd1; step("R8 both flags");
        blank_i = 1; step("R9 blank over all-on"); blank_i = 0;
        set_flags(0, 1); step("R7 all-off");
        set_flags(0, 0); step("R2 normal");
        // random mix
        for (int t = 0; t < 4000; t++) begin
            digit_idx      = 4'($urandom % 16);
            blank_i        = ($urandom % 8) == 0;
            digit_cnt_code = (($urandom % 4) == 0) ? 3'($urandom) : 3'd0;
            if (($urandom % 4) == 0) begin code_we = 1; code_waddr = 4'($urandom); code_wdata = 8'($urandom % 24); end
            if (($urandom % 4) == 0) begin pat_we = 1; pat_waddr = 3'($urandom); pat_wdata = 35'({$urandom, $urandom}); end
            if (($urandom % 4) == 0) begin sym_we = 1; sym_waddr = 4'($urandom); sym_wdata = 2'($urandom); end
            if (($urandom % 16) == 0) begin
                lamp_wr = 1; lamp_on_d = ($urandom % 4) == 0; lamp_off_d = ($urandom % 4) == 0;
            end else begin
                lamp_on_d = 1'($urandom); lamp_off_d = 1'($urandom);
            end
            step("random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule